// File: doc/BRIEF.md
# Coprocessor Control and Error Register Block

This block is the register front end of a vector rendering coprocessor. A host reaches it over a simple 32-bit request/acknowledge register bus. It holds the control/status word, an error word that shows the latched faults, a diagnostics register, a soft-reset register and a sync register. The execution engine reports faults, activity and register-bank writes to it as single-cycle strobes. The block drives the run enable, the page-bound check enable, the serialised-execution control and an error interrupt.

A request is accepted when `bus_sel_i` is high and the state machine is in ST_IDLE. The transition ST_IDLE to ST_REPLY performs the write or captures the read data. ST_REPLY raises `bus_ack_o` for one cycle and then returns to ST_IDLE. A write to the sync register while the engine is busy takes the transition ST_IDLE to ST_STALL instead. The machine stays in ST_STALL while `eng_busy_i` is high. It takes ST_STALL to ST_REPLY on the first edge at which the engine is idle. The host holds its request until it sees the acknowledge and then drops `bus_sel_i`.

Top module: `cop_csr_top`

## Requirements
- R1: After reset, `run_o`, `pbchk_en_o`, `serial_o` and `irq_o` are 0. The diagnostics register (offset 0x1C) reads 0x00004804. The error register (0x04) reads 0. With the engine idle and its queue empty, control/status (0x00) reads 0x00004000.
- R2: In control/status, bit 7 (error interrupt enable), bit 10 (page-bound check enable) and bit 12 (run) are read/write. Bit 12 drives `run_o` and bit 10 drives `pbchk_en_o`. Written values in other bits never set those bits.
- R3: Each error strobe `eng_err_i[k]` sets bit k of control/status and bit k of the error register, for k = 0..5. Bit 0 is illegal instruction, bit 1 page-bound error, bit 2 illegal memory access, bit 3 illegal register access, bit 4 alignment violation and bit 5 illegal queue write. A set bit stays set after the strobe ends.
- R4: Writing 1 to bit k (k = 0..5) at offset 0x00 or 0x04 clears error bit k. Writing 0 leaves the bit unchanged. A strobe at the same clock edge as the clearing write leaves the bit set.
- R5: `irq_o` is 1 exactly when the interrupt enable (control/status bit 7) is 1 and at least one error bit is set. Bit 7 of the error register reads this same pending state.
- R6: A `eng_memwr_i` strobe sets control/status bit 11. A `eng_bankwr_i[b]` strobe sets bit 16+b, where bank b covers registers 32b to 32b+31. These bits are sticky and are cleared by writing 1 to them at offset 0x00.
- R7: Control/status bit 14 reads the live `eng_qempty_i` and bit 15 reads the live `eng_busy_i`, both sampled at the clock edge that accepts the read.
- R8: The diagnostics register at 0x1C is 32-bit read/write, and its bit 1 drives `serial_o`.
- R9: A write of any value to offset 0x30 returns all registers to their reset values. This includes run = 0, interrupt enable = 0, cleared error and flag bits, and diagnostics = 0x4804.
- R10: A write to the sync register at 0x34 is not acknowledged while `eng_busy_i` is 1. Its acknowledge comes one cycle after the edge at which `eng_busy_i` is first seen low. Reads of 0x30, 0x34 and unmapped offsets return 0.
- R11: Every access that is not stalled is acknowledged with `bus_ack_o` high for exactly one cycle, in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while `bus_ack_o` is high |
| bus_ack_o | output | 1 | One-cycle access acknowledge |
| eng_err_i | input | 6 | Error cause strobes |
| eng_busy_i | input | 1 | Engine executing or instruction pending |
| eng_qempty_i | input | 1 | Instruction queue empty |
| eng_memwr_i | input | 1 | Engine performed a memory write |
| eng_bankwr_i | input | 4 | Engine wrote register bank 0..3 |
| run_o | output | 1 | Engine run enable |
| pbchk_en_o | output | 1 | Page-bound checking enable |
| serial_o | output | 1 | Force serialised execution |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench drives three kinds of error-cause pattern: single separated bits, a low-end pair, and the top bit. These show whether the cause order and bit placement are right in both register views. Clears are tried with a 1 in one position, with all-zero data, and with a strobe landing on the clearing edge. This separates write-one-to-clear from plain overwrite and shows whether set wins over clear. The sync write is issued once while the engine is busy and once while it is idle. This separates a real stall from a fixed delay. A soft reset is issued with every kind of state set, which shows whether any register escapes it.

// File: rtl/cop_csr_pkg.sv
package cop_csr_pkg;

    // register byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_ERR  = 8'h04;
    localparam logic [7:0] OFF_DIAG = 8'h1C;
    localparam logic [7:0] OFF_SRST = 8'h30;
    localparam logic [7:0] OFF_SYNC = 8'h34;

    // control/status bit positions
    localparam int ERR_LSB  = 0;
    localparam int BIT_IE   = 7;
    localparam int BIT_PB   = 10;
    localparam int BIT_WO   = 11;
    localparam int BIT_GO   = 12;
    localparam int BIT_QE   = 14;
    localparam int BIT_BZ   = 15;
    localparam int BANK_LSB = 16;

    // error register: pending interrupt position
    localparam int BIT_PEND = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_REPLY = 2'd2
    } csr_state_e;

endpackage

// File: rtl/cop_csr_bus_fsm.sv
module cop_csr_bus_fsm
    import cop_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              eng_busy_i,
    output logic              accept_o,
    output logic              ack_o,
    output logic              stall_o
);

    csr_state_e state_q, state_d;
    logic       is_sync_wr;

    assign is_sync_wr = we_i && (addr_i == ADDR_W'(OFF_SYNC));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_i) begin
                    if (is_sync_wr && eng_busy_i) begin
                        state_d = ST_STALL;
                    end else begin
                        state_d = ST_REPLY;
                    end
                end
            end
            ST_STALL: begin
                if (!eng_busy_i) begin
                    state_d = ST_REPLY;
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        ack_o    = 1'b0;
        stall_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept_o = sel_i;
            ST_STALL: stall_o  = 1'b1;
            ST_REPLY: ack_o    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cop_csr_sticky.sv
module cop_csr_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (srst_i) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cop_csr_top.sv
module cop_csr_top
    import cop_csr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          N_ERR    = 6,
    parameter int          N_BANK   = 4,
    parameter logic [31:0] DIAG_RST = 32'h0000_4804
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_ack_o,
    input  logic [N_ERR-1:0]  eng_err_i,
    input  logic              eng_busy_i,
    input  logic              eng_qempty_i,
    input  logic              eng_memwr_i,
    input  logic [N_BANK-1:0] eng_bankwr_i,
    output logic              run_o,
    output logic              pbchk_en_o,
    output logic              serial_o,
    output logic              irq_o
);

    localparam int N_FLAG = N_BANK + 1;

    logic              accept, fsm_stall;
    logic              wr_ctrl, wr_err, wr_diag, soft_rst;
    logic              irq_en_q, pb_q, run_q;
    logic [DATA_W-1:0] diag_q;
    logic [N_ERR-1:0]  err_q, err_clr;
    logic [N_FLAG-1:0] flag_q, flag_clr, flag_set;
    logic [DATA_W-1:0] rd_ctrl, rd_err, rd_mux, rdata_q;
    logic              pending;

    cop_csr_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel_i),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .eng_busy_i (eng_busy_i),
        .accept_o   (accept),
        .ack_o      (bus_ack_o),
        .stall_o    (fsm_stall)
    );

    // write decode
    always_comb begin
        wr_ctrl  = accept && bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
        wr_err   = accept && bus_we_i && (bus_addr_i == ADDR_W'(OFF_ERR));
        wr_diag  = accept && bus_we_i && (bus_addr_i == ADDR_W'(OFF_DIAG));
        soft_rst = accept && bus_we_i && (bus_addr_i == ADDR_W'(OFF_SRST));
    end

    // write-one-to-clear vectors
    always_comb begin
        err_clr  = (wr_ctrl || wr_err) ? bus_wdata_i[ERR_LSB +: N_ERR] : '0;
        flag_clr = wr_ctrl ? {bus_wdata_i[BANK_LSB +: N_BANK], bus_wdata_i[BIT_WO]} : '0;
        flag_set = {eng_bankwr_i, eng_memwr_i};
    end

    cop_csr_sticky #(.W(N_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_i (soft_rst),
        .set_i  (eng_err_i),
        .clr_i  (err_clr),
        .q_o    (err_q)
    );

    cop_csr_sticky #(.W(N_FLAG)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_i (soft_rst),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .q_o    (flag_q)
    );

    // configuration bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            pb_q     <= 1'b0;
            run_q    <= 1'b0;
            diag_q   <= DATA_W'(DIAG_RST);
        end else if (soft_rst) begin
            irq_en_q <= 1'b0;
            pb_q     <= 1'b0;
            run_q    <= 1'b0;
            diag_q   <= DATA_W'(DIAG_RST);
        end else begin
            if (wr_ctrl) begin
                irq_en_q <= bus_wdata_i[BIT_IE];
                pb_q     <= bus_wdata_i[BIT_PB];
                run_q    <= bus_wdata_i[BIT_GO];
            end
            if (wr_diag) begin
                diag_q <= bus_wdata_i;
            end
        end
    end

    assign pending = irq_en_q && (|err_q);

    // read words
    always_comb begin
        rd_ctrl                       = '0;
        rd_ctrl[ERR_LSB +: N_ERR]     = err_q;
        rd_ctrl[BIT_IE]               = irq_en_q;
        rd_ctrl[BIT_PB]               = pb_q;
        rd_ctrl[BIT_WO]               = flag_q[0];
        rd_ctrl[BIT_GO]               = run_q;
        rd_ctrl[BIT_QE]               = eng_qempty_i;
        rd_ctrl[BIT_BZ]               = eng_busy_i;
        rd_ctrl[BANK_LSB +: N_BANK]   = flag_q[N_FLAG-1:1];
        rd_err                        = '0;
        rd_err[ERR_LSB +: N_ERR]      = err_q;
        rd_err[BIT_PEND]              = pending;
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr_i == ADDR_W'(OFF_CTRL)) begin
            rd_mux = rd_ctrl;
        end else if (bus_addr_i == ADDR_W'(OFF_ERR)) begin
            rd_mux = rd_err;
        end else if (bus_addr_i == ADDR_W'(OFF_DIAG)) begin
            rd_mux = diag_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !bus_we_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata_o = rdata_q;
    assign run_o       = run_q;
    assign pbchk_en_o  = pb_q;
    assign serial_o    = diag_q[1];
    assign irq_o       = pending;

endmodule

// File: rtl/cop_csr_chk.sv
module cop_csr_chk #(
    parameter int N_ERR = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ack_o,
    input logic             eng_busy_i,
    input logic             fsm_stall,
    input logic [N_ERR-1:0] err_q,
    input logic [N_ERR-1:0] err_clr,
    input logic [N_ERR-1:0] eng_err_i,
    input logic             soft_rst,
    input logic             wr_ctrl,
    input logic             irq_en_q,
    input logic             run_o,
    input logic             irq_o
);

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |=> !bus_ack_o); // R11

    AST_SYNC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_stall && eng_busy_i) |=> !bus_ack_o); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((err_q & $past(err_q & ~err_clr)) == $past(err_q & ~err_clr))); // R3

    AST_IRQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eng_err_i) && irq_en_q && !soft_rst && !wr_ctrl) |=> irq_o); // R5

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!run_o && !irq_o)); // R9

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl && !soft_rst) |=> $stable(run_o)); // R2

endmodule

bind cop_csr_top cop_csr_chk #(.N_ERR(N_ERR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ack_o  (bus_ack_o),
    .eng_busy_i (eng_busy_i),
    .fsm_stall  (fsm_stall),
    .err_q      (err_q),
    .err_clr    (err_clr),
    .eng_err_i  (eng_err_i),
    .soft_rst   (soft_rst),
    .wr_ctrl    (wr_ctrl),
    .irq_en_q   (irq_en_q),
    .run_o      (run_o),
    .irq_o      (irq_o)
);

// File: tb/cop_csr_top_tb_top.sv
module cop_csr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [5:0]  eng_err = '0;
    logic        eng_busy = 1'b0;
    logic        eng_qempty = 1'b1;
    logic        eng_memwr = 1'b0;
    logic [3:0]  eng_bankwr = '0;
    logic        run, pbchk_en, serial, irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic cur_we = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    cop_csr_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel_i    (bus_sel),
        .bus_we_i     (bus_we),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_ack_o    (bus_ack),
        .eng_err_i    (eng_err),
        .eng_busy_i   (eng_busy),
        .eng_qempty_i (eng_qempty),
        .eng_memwr_i  (eng_memwr),
        .eng_bankwr_i (eng_bankwr),
        .run_o        (run),
        .pbchk_en_o   (pbchk_en),
        .serial_o     (serial),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor: compare read data against the expected queue
    always @(negedge clk) begin
        if (bus_ack && !cur_we) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read ack", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            summary();
        end
    end

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d, output int lat);
        @(negedge clk);
        cur_we    = we;
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        lat = 0;
        @(negedge clk);
        lat = 1;
        while (!bus_ack) begin
            @(negedge clk);
            lat++;
        end
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int lat;
        xfer(1'b1, a, d, lat);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        int lat;
        exp_q.push_back(e);
        tag_q.push_back(t);
        xfer(1'b0, a, 32'h0, lat);
    endtask

    task automatic pulse_err(input logic [5:0] v);
        @(negedge clk);
        eng_err = v;
        @(negedge clk);
        eng_err = '0;
    endtask

    initial begin
        int  lat;
        bit  stall_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 run_o", {31'b0, run}, 32'h0);
        chk("R1 pbchk_en_o", {31'b0, pbchk_en}, 32'h0);
        chk("R1 serial_o", {31'b0, serial}, 32'h0);
        chk("R1 irq_o", {31'b0, irq}, 32'h0);
        rd(8'h00, 32'h0000_4000, "R1 ctrl reset");
        rd(8'h1C, 32'h0000_4804, "R1 diag reset");
        rd(8'h04, 32'h0000_0000, "R1 err reset");

        // R11 single-cycle acknowledge
        xfer(1'b0, 8'h1C, 32'h0, lat);
        chk("R11 ack latency", lat, 1);
        exp_q.push_front(32'h0000_4804);
        tag_q.push_front("R11 diag read");
        @(negedge clk);
        chk("R11 ack width", {31'b0, bus_ack}, 32'h0);

        // R2 writable control bits
        wr(8'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 run_o set", {31'b0, run}, 32'h1);
        chk("R2 pbchk_en_o set", {31'b0, pbchk_en}, 32'h1);
        rd(8'h00, 32'h0000_5480, "R2 ctrl all ones");
        wr(8'h00, 32'h0000_0000);
        @(negedge clk);
        chk("R2 run_o clear", {31'b0, run}, 32'h0);

        // R3 / R5 error causes
        pulse_err(6'b000101);
        rd(8'h00, 32'h0000_4005, "R3 ctrl err bits");
        rd(8'h04, 32'h0000_0005, "R3 err reg");
        chk("R5 irq without enable", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0000_0080);
        @(negedge clk);
        chk("R5 irq with enable", {31'b0, irq}, 32'h1);
        rd(8'h04, 32'h0000_0085, "R5 pending bit");
        pulse_err(6'b100000);
        rd(8'h04, 32'h0000_00A5, "R3 top cause bit");

        // R4 clearing
        wr(8'h04, 32'h0000_0001);
        rd(8'h04, 32'h0000_00A4, "R4 w1c via err reg");
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, 32'h0000_00A4, "R4 write zero no effect");
        wr(8'h00, 32'h0000_00A4);
        rd(8'h00, 32'h0000_4080, "R4 w1c via ctrl");
        chk("R5 irq drops with no errors", {31'b0, irq}, 32'h0);

        // R4 set wins over clear at the same edge
        @(negedge clk);
        cur_we = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h2;
        eng_err = 6'b000010;
        @(negedge clk);
        eng_err = '0;
        chk("R11 ack on set-wins write", {31'b0, bus_ack}, 32'h1);
        bus_sel = 1'b0;
        rd(8'h04, 32'h0000_0082, "R4 set wins");
        wr(8'h04, 32'h0000_0002);
        rd(8'h04, 32'h0000_0000, "R4 cleared after");

        // R6 memory-write and bank flags
        @(negedge clk);
        eng_memwr = 1'b1; eng_bankwr = 4'b1010;
        @(negedge clk);
        eng_memwr = 1'b0; eng_bankwr = 4'b0000;
        rd(8'h00, 32'h000A_4880, "R6 flags set");
        wr(8'h00, 32'h0002_0880);
        rd(8'h00, 32'h0008_4080, "R6 flags w1c");

        // R7 live status
        @(negedge clk);
        eng_qempty = 1'b0; eng_busy = 1'b1;
        rd(8'h00, 32'h0008_8080, "R7 live busy/empty");
        eng_qempty = 1'b1; eng_busy = 1'b0;

        // R8 diagnostics
        wr(8'h1C, 32'h0000_0002);
        @(negedge clk);
        chk("R8 serial_o", {31'b0, serial}, 32'h1);
        rd(8'h1C, 32'h0000_0002, "R8 diag readback");

        // R10 sync stall
        @(negedge clk);
        eng_busy = 1'b1;
        cur_we = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h0;
        stall_bad = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_ack) stall_bad = 1'b1;
        end
        chk("R10 no ack while busy", {31'b0, stall_bad}, 32'h0);
        eng_busy = 1'b0;
        @(negedge clk);
        chk("R10 ack after idle", {31'b0, bus_ack}, 32'h1);
        bus_sel = 1'b0;
        xfer(1'b1, 8'h34, 32'h0, lat);
        chk("R10 sync idle latency", lat, 1);
        rd(8'h30, 32'h0, "R10 srst reads zero");
        rd(8'h34, 32'h0, "R10 sync reads zero");
        rd(8'h40, 32'h0, "R10 unmapped reads zero");

        // R9 soft reset
        wr(8'h00, 32'h0000_1480);
        pulse_err(6'b010000);
        @(negedge clk);
        chk("R9 pre run_o", {31'b0, run}, 32'h1);
        chk("R9 pre irq_o", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R9 run_o cleared", {31'b0, run}, 32'h0);
        chk("R9 irq_o cleared", {31'b0, irq}, 32'h0);
        chk("R9 serial_o restored", {31'b0, serial}, 32'h0);
        rd(8'h00, 32'h0000_4000, "R9 ctrl restored");
        rd(8'h1C, 32'h0000_4804, "R9 diag restored");
        rd(8'h04, 32'h0000_0000, "R9 err restored");

        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule